// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host requests into timed strobe sequences on an asynchronous NAND flash bus. A request names one of three targets: a command byte (CLE high), an address byte (ALE high) or a data word. Data can be written or read, and command and address bytes are always written. Each accepted request runs through a fixed series of phases. A setup phase drops chip enable while the strobe stays high. A strobe phase pulses the write or read strobe low. A hold phase keeps chip enable and write data steady after the strobe rises. After a read only, a turnaround phase releases the bus before the next access. Each phase length comes from its own 8-bit field in a timing word and is counted in controller clocks.

A control word supplies the enables, the 8/16-bit width selection and two 4-bit gaps. The gaps lengthen the setup phase of a data read when the access just before it was a command (command-to-read gap) or an address (address-to-read gap). When waiting is enabled, a low ready/busy input holds off new cycles. The host side is a valid/ready handshake: ready is low from acceptance until the last phase of the access has ended.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, chip-enable, write-strobe and read-strobe outputs are high, CLE, ALE, the data output enable and the response valid are low.
- R2: The timing word carries setup in bits 7:0, strobe (wait) in 15:8, hold in 23:16 and turnaround in 31:24; the control word carries halt (bit 0), wait-on-ready enable (bit 1), bank enable (bit 2), 16-bit width (bit 4), command-to-read gap in bits 12:9 and address-to-read gap in bits 16:13.
- R3: After acceptance the setup phase lasts setup+1 clocks with chip enable low and both strobes high; CLE is high through the access for a command (kind 0), ALE for an address (kind 1), neither for data (kind 2).
- R4: The strobe phase lasts wait+1 clocks; writes pulse the write strobe and drive the data output enable from setup through hold, reads pulse the read strobe with the bus released.
- R5: The hold phase lasts hold clocks with chip enable low and both strobes high; a hold field of zero gives one clock.
- R6: After a data read, chip enable goes high and the bus stays released for turnaround clocks (none when the field is zero) before ready returns; writes have no turnaround phase.
- R7: A data read accepted right after a command adds the command-to-read gap to its setup phase; right after an address it adds the address-to-read gap; after any data access it adds nothing.
- R8: Read data is sampled in the last strobe clock and presented with a one-clock response valid pulse in the first hold clock.
- R9: While bank enable is cleared, ready stays low and no cycle starts.
- R10: With wait-on-ready enabled, ready stays low while the ready/busy input is low, and the access starts once it goes high.
- R11: In 16-bit mode data words use all 16 bus bits; in 8-bit mode, and for every command or address byte, bus bits 15:8 are driven and returned as zero.
- R12: While the halt bit is set, ready stays low and no cycle starts.
- R13: Ready is low from the clock after acceptance until the final phase ends, then returns high, so one access spans exactly its phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Control word (enables, width, read gaps) |
| tim_word | input | 32 | Timing word (setup, strobe, hold, turnaround) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_kind | input | 2 | 0 command, 1 address, 2 data |
| req_write | input | 1 | Data direction for kind 2 (1 write, 0 read) |
| req_wdata | input | 16 | Write data or command/address byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| nand_rb | input | 1 | Flash ready/busy, high when ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Bus output data |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 16 | Bus input data |

## Verification
The hardest case to reach is the gap on a data read. Its length depends on the kind of the previous accepted access, which the ports never show. The bench sets that history on purpose by issuing an address or a command byte just before each read. It then issues read after read, which must add no gap. Phase lengths are measured from the pins alone: a cycle with chip enable low and the strobe high counts as setup before the strobe falls and as hold after it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int TIME_W = 8;
  localparam int GAP_W  = 4;
  localparam int CNT_W  = TIME_W + 2;

  // control word bit positions
  localparam int CB_HALT   = 0;
  localparam int CB_WAITEN = 1;
  localparam int CB_BANK   = 2;
  localparam int CB_WIDE   = 4;
  localparam int CB_CLGAP  = 9;
  localparam int CB_ALGAP  = 13;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2
  } acc_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_HIZ
  } phase_t;

  typedef struct packed {
    logic              halt;
    logic              wait_en;
    logic              bank_en;
    logic              wide;
    logic [GAP_W-1:0]  cl_gap;
    logic [GAP_W-1:0]  al_gap;
    logic [TIME_W-1:0] t_setup;
    logic [TIME_W-1:0] t_wait;
    logic [TIME_W-1:0] t_hold;
    logic [TIME_W-1:0] t_hiz;
  } bus_cfg_t;

endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] ctl_word,
  input  logic [31:0] tim_word,
  output bus_cfg_t    cfg
);

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl_word[31:17], ctl_word[8:5], ctl_word[3]};

  always_comb begin
    cfg.halt    = ctl_word[CB_HALT];
    cfg.wait_en = ctl_word[CB_WAITEN];
    cfg.bank_en = ctl_word[CB_BANK];
    cfg.wide    = ctl_word[CB_WIDE];
    cfg.cl_gap  = ctl_word[CB_CLGAP +: GAP_W];
    cfg.al_gap  = ctl_word[CB_ALGAP +: GAP_W];
    cfg.t_setup = tim_word[0*TIME_W +: TIME_W];
    cfg.t_wait  = tim_word[1*TIME_W +: TIME_W];
    cfg.t_hold  = tim_word[2*TIME_W +: TIME_W];
    cfg.t_hiz   = tim_word[3*TIME_W +: TIME_W];
  end

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_cfg_t  cfg,
  input  logic      req_valid,
  input  acc_kind_t req_kind,
  input  logic      req_write,
  input  logic      nand_rb,
  output logic      req_ready,
  output logic      accept,
  output phase_t    phase,
  output acc_kind_t cur_kind,
  output logic      cur_write,
  output logic      capture
);

  logic [CNT_W-1:0] cnt;
  acc_kind_t        prev_kind;
  logic [GAP_W-1:0] gap;
  logic             eff_write;
  logic             unused_cfg;

  assign unused_cfg = cfg.wide;

  assign req_ready = (phase == PH_IDLE) && cfg.bank_en && !cfg.halt &&
                     (!cfg.wait_en || nand_rb);
  assign accept    = req_ready && req_valid;
  assign eff_write = (req_kind != K_DATA) || req_write;
  assign capture   = (phase == PH_STROBE) && (cnt == '0) && !cur_write;

  always_comb begin
    gap = '0;
    if (!eff_write) begin
      if (prev_kind == K_CMD)       gap = cfg.cl_gap;
      else if (prev_kind == K_ADDR) gap = cfg.al_gap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_kind  <= K_DATA;
      cur_write <= 1'b1;
      prev_kind <= K_DATA;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase     <= PH_SETUP;
          cnt       <= CNT_W'(cfg.t_setup) + CNT_W'(gap);
          cur_kind  <= req_kind;
          cur_write <= eff_write;
          prev_kind <= req_kind;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(cfg.t_wait);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= (cfg.t_hold == '0) ? '0 : CNT_W'(cfg.t_hold) - 1'b1;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          if (!cur_write && cfg.t_hiz != '0) begin
            phase <= PH_HIZ;
            cnt   <= CNT_W'(cfg.t_hiz) - 1'b1;
          end else phase <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        PH_HIZ: if (cnt == '0) phase <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_accept_busy_R13: assert property (@(posedge clk) disable iff (rst)
    accept |=> (phase == PH_SETUP) && !req_ready);
  assert_bank_off_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !cfg.bank_en) |=> (phase == PH_IDLE));
  assert_halt_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && cfg.halt) |=> (phase == PH_IDLE));
  assert_busy_wait_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && cfg.wait_en && !nand_rb) |=> (phase == PH_IDLE));
  assert_hiz_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIZ) |-> !cur_write);

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide,
  input  logic            accept,
  input  acc_kind_t       req_kind,
  input  logic [DQ_W-1:0] req_wdata,
  input  phase_t          phase,
  input  acc_kind_t       cur_kind,
  input  logic            cur_write,
  input  logic            capture,
  input  logic [DQ_W-1:0] nand_dq_in,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DQ_W-1:0] nand_dq_out,
  output logic            nand_dq_oe,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_rdata
);

  localparam int BYTE_W = 8;
  localparam int HI_W   = DQ_W - BYTE_W;

  logic [DQ_W-1:0] wdata_q;
  logic            active;

  assign active      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign nand_ce_n   = !active;
  assign nand_cle    = active && (cur_kind == K_CMD);
  assign nand_ale    = active && (cur_kind == K_ADDR);
  assign nand_we_n   = !((phase == PH_STROBE) && cur_write);
  assign nand_re_n   = !((phase == PH_STROBE) && !cur_write);
  assign nand_dq_oe  = active && cur_write;
  assign nand_dq_out = nand_dq_oe ? wdata_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        if (wide && req_kind == K_DATA) wdata_q <= req_wdata;
        else wdata_q <= {{HI_W{1'b0}}, req_wdata[BYTE_W-1:0]};
      end
      rsp_valid <= capture;
      if (capture) begin
        if (wide) rsp_rdata <= nand_dq_in;
        else rsp_rdata <= {{HI_W{1'b0}}, nand_dq_in[BYTE_W-1:0]};
      end
    end
  end

  assert_strobe_in_ce_R4: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!nand_re_n) && nand_re_n);
  assert_released_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe);

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     ctl_word,
  input  logic [31:0]     tim_word,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_write,
  input  logic [DQ_W-1:0] req_wdata,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_rdata,
  input  logic            nand_rb,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DQ_W-1:0] nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DQ_W-1:0] nand_dq_in
);

  bus_cfg_t  cfg;
  phase_t    phase;
  acc_kind_t cur_kind;
  acc_kind_t kind_in;
  logic      cur_write;
  logic      accept;
  logic      capture;

  assign kind_in = acc_kind_t'(req_kind);

  nand_cfg_decode u_cfg (
    .ctl_word (ctl_word),
    .tim_word (tim_word),
    .cfg      (cfg)
  );

  nand_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .req_valid (req_valid),
    .req_kind  (kind_in),
    .req_write (req_write),
    .nand_rb   (nand_rb),
    .req_ready (req_ready),
    .accept    (accept),
    .phase     (phase),
    .cur_kind  (cur_kind),
    .cur_write (cur_write),
    .capture   (capture)
  );

  nand_pin_drive #(.DQ_W(DQ_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .wide        (cfg.wide),
    .accept      (accept),
    .req_kind    (kind_in),
    .req_wdata   (req_wdata),
    .phase       (phase),
    .cur_kind    (cur_kind),
    .cur_write   (cur_write),
    .capture     (capture),
    .nand_dq_in  (nand_dq_in),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  assert_cle_ale_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
module test_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctl_word = '0;
  logic [31:0] tim_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b1;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        nand_rb = 1'b1;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rst(rst), .ctl_word(ctl_word), .tim_word(tim_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .nand_rb(nand_rb), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tw(input int s, input int w, input int h, input int z);
    return {8'(z), 8'(h), 8'(w), 8'(s)};
  endfunction

  function automatic logic [31:0] cw(input bit halt, input bit wen, input bit ben,
                                     input bit wide, input int clg, input int alg);
    logic [31:0] v = '0;
    v[0] = halt; v[1] = wen; v[2] = ben; v[3] = 1'b1; v[4] = wide;
    v[12:9] = 4'(clg); v[16:13] = 4'(alg);
    return v;
  endfunction

  // Issues one access and measures each phase from the pins.
  task automatic do_access(input string req, input logic [1:0] kind, input logic wr,
                           input logic [15:0] wd, input int es, input int ew,
                           input int eh, input int ez, input logic [15:0] exp_out,
                           input logic [15:0] exp_rd);
    int ns = 0, nw = 0, nh = 0, nz = 0, waitc = 0, bad = 0;
    bit seen = 0, got = 0, wrs;
    logic [15:0] rd = '0;
    wrs = (kind != 2'd2) || wr;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr; req_wdata = wd;
    while (!req_ready && waitc < 50) begin @(negedge clk); waitc++; end
    check(req_ready, req, "ready before access", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000 && !req_ready; i++) begin
      if ((wrs ? !nand_re_n : !nand_we_n)) bad++;
      if (!nand_ce_n && (kind == 2'd0) != nand_cle) bad++;
      if (!nand_ce_n && (kind == 2'd1) != nand_ale) bad++;
      if (!nand_ce_n && nand_dq_oe != wrs) bad++;
      if (nand_ce_n && nand_dq_oe) bad++;
      if (wrs ? !nand_we_n : !nand_re_n) begin nw++; seen = 1; end
      else if (!nand_ce_n && !seen) begin
        ns++;
        if (wrs && nand_dq_out != exp_out) bad++;
      end else if (!nand_ce_n) begin
        if (rsp_valid) begin got = (nh == 0); rd = rsp_rdata; end
        nh++;
      end else nz++;
      @(negedge clk);
    end
    check(ns == es, req, "setup clocks", ns, es);
    check(nw == ew, req, "strobe clocks", nw, ew);
    check(nh == eh, req, "hold clocks", nh, eh);
    check(nz == ez, req, "turnaround clocks", nz, ez);
    check(bad == 0, req, "pin level violations", bad, 0);
    check(ns + nw + nh + nz == es + ew + eh + ez, "R13", "busy span",
          ns + nw + nh + nz, es + ew + eh + ez);
    if (!wrs) begin
      check(got, "R8", "response pulse in first hold clock", got, 1);
      check(rd == exp_rd, req, "read data", rd, exp_rd);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n, "R1", "strobes/ce high after reset",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    check(!nand_cle && !nand_ale && !nand_dq_oe && !rsp_valid, "R1", "low outputs after reset",
          {nand_cle, nand_ale, nand_dq_oe, rsp_valid}, 0);
  endtask

  // R2 R3 R4 R5: command and address writes with distinct timing fields
  task automatic t_cmd_addr();
    ctl_word = cw(0, 0, 1, 0, 0, 0);
    tim_word = tw(2, 3, 2, 4);
    do_access("R3", 2'd0, 1'b1, 16'hAB90, 3, 4, 2, 0, 16'h0090, 16'h0);
    tim_word = tw(1, 1, 1, 0);
    do_access("R2", 2'd1, 1'b1, 16'h1234, 2, 2, 1, 0, 16'h0034, 16'h0);
  endtask

  // R7 R6 R8: reads after address, after command, after data
  task automatic t_read_gaps();
    ctl_word = cw(0, 0, 1, 1, 5, 2);
    tim_word = tw(1, 2, 1, 3);
    nand_dq_in = 16'hA55A;
    do_access("R4", 2'd1, 1'b1, 16'h0007, 2, 3, 1, 0, 16'h0007, 16'h0);
    do_access("R7", 2'd2, 1'b0, 16'h0, 4, 3, 1, 3, 16'h0, 16'hA55A);
    do_access("R6", 2'd2, 1'b0, 16'h0, 2, 3, 1, 3, 16'h0, 16'hA55A);
    do_access("R3", 2'd0, 1'b1, 16'h0030, 2, 3, 1, 0, 16'h0030, 16'h0);
    nand_dq_in = 16'h3C96;
    do_access("R7", 2'd2, 1'b0, 16'h0, 7, 3, 1, 3, 16'h0, 16'h3C96);
  endtask

  // R5 R11 R6: zero hold, 8/16-bit data, zero turnaround
  task automatic t_width_hold();
    ctl_word = cw(0, 0, 1, 0, 0, 0);
    tim_word = tw(0, 0, 0, 0);
    do_access("R5", 2'd2, 1'b1, 16'h1234, 1, 1, 1, 0, 16'h0034, 16'h0);
    nand_dq_in = 16'hBE5A;
    do_access("R11", 2'd2, 1'b0, 16'h0, 1, 1, 1, 0, 16'h0, 16'h005A);
    ctl_word = cw(0, 0, 1, 1, 0, 0);
    do_access("R11", 2'd2, 1'b1, 16'h1234, 1, 1, 1, 0, 16'h1234, 16'h0);
    do_access("R11", 2'd0, 1'b1, 16'hFF70, 1, 1, 1, 0, 16'h0070, 16'h0);
  endtask

  // R9 R12: disabled or halted sequencer ignores a waiting request
  task automatic t_block(input string req, input logic [31:0] ctl);
    int starts = 0, rdy = 0;
    ctl_word = ctl;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!nand_ce_n) starts++;
      if (req_ready) rdy++;
    end
    check(starts == 0, req, "no cycle while blocked", starts, 0);
    check(rdy == 0, req, "ready low while blocked", rdy, 0);
    req_valid = 1'b0;
    ctl_word = cw(0, 0, 1, 1, 0, 0);
    tim_word = tw(0, 0, 1, 0);
    do_access(req, 2'd0, 1'b1, 16'h00EE, 1, 1, 1, 0, 16'h00EE, 16'h0);
  endtask

  // R10: busy input holds off the access until it rises
  task automatic t_busy();
    int starts = 0, rdy = 0;
    ctl_word = cw(0, 1, 1, 1, 0, 0);
    tim_word = tw(1, 1, 2, 0);
    nand_rb = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_write = 1'b1; req_wdata = 16'h0021;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!nand_ce_n) starts++;
      if (req_ready) rdy++;
    end
    check(starts == 0 && rdy == 0, "R10", "held off while busy", starts + rdy, 0);
    nand_rb = 1'b1;
    do_access("R10", 2'd1, 1'b1, 16'h0021, 2, 2, 2, 0, 16'h0021, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cmd_addr();
    t_read_gaps();
    t_width_hold();
    t_block("R9", cw(0, 0, 0, 1, 0, 0));
    t_block("R12", cw(1, 0, 1, 1, 0, 0));
    t_busy();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule